// File: doc/BRIEF.md
# Dual-Clock Frame Buffer Pointer Controller

This block is the address and control core of a frame memory with two clock domains. The write side takes 12-bit samples on its own clock, and its write pointer advances one step per enabled cycle. The read side fetches samples on a second clock without consuming them. Either pointer can be cleared to zero or loaded with a target address, and it stays there for as long as the control pin is held low. The target is either a programmed preset value or the low bits of a shared 24-bit address bus.

When the memory is full, writing does not stop: new samples replace the oldest ones. When the reader catches up with the writer, the read pointer stops, and the last written sample is returned again until more data arrives. This stop applies only until the first read-side pointer load after reset. A write inhibit blocks storage but does not stop the write pointer.

Two programmable flags report how full the buffer is. Each flag is computed in its own clock domain, using the other pointer passed across in Gray code. Several instances can share one seamless address space. Each instance stores and drives only the slice of the address space that its base position selects. A width mode chooses which of the 12 data bits are used, and a per-bit output-enable vector tells the pads which bits to drive.

Top module: `framebuf_ptr_ctrl`

## Requirements
- R1: A sample on `dIn` is stored at the write pointer on a `wrClk` rising edge only if `wrEnN` was low at the previous `wrClk` rising edge. The write pointer then advances by one.
- R2: With `storeEnN` high at that edge, the memory location keeps its old contents. The write pointer still advances.
- R3: Both pointers wrap modulo the span. The span is 2^ADDR_W locations times 2^`cascLog` instances. Writing past a full buffer overwrites the oldest locations.
- R4: Until the first read-side clear or set after reset, a read with the read pointer equal to the synchronised write pointer returns the sample at the read pointer minus one. In that case the read pointer does not move.
- R5: `wrClrN`/`rdClrN` low at a rising edge of their clock zeroes that pointer. Otherwise, `wrSetN`/`rdSetN` low loads the target address. Clear takes priority over set. At a loading edge there is no store (write side) and no fetch (read side).
- R6: While a clear or set pin stays low, it reloads the pointer at every edge. Normal advance resumes at the first edge with the pin high.
- R7: The target address comes from `wrPreset`/`rdPreset` when `wrSelExt`/`rdSelExt` is 0. When it is 1, the target is `extAddr[PTR_W-1:0]`. In both cases the target is masked to the span.
- R8: A fetch updates `qOut` at the second `rdClk` rising edge after `rdEnN` is first seen low. If `rdEnN` is high at an edge, the next edge does not fetch, and `qOut` holds its value. After reset, `qOut` and `qOe` are 0.
- R9: `widthMode` selects the bits in use: 0 uses bits [11:4], 1 or 3 uses bits [11:2], and 2 uses bits [11:0]. Unused bits are stored as 0, read as 0, and have `qOe` low.
- R10: An address belongs to this instance when address bits [PTR_W-1:ADDR_W] equal `cascBase`. Samples at addresses that are not owned are not stored. A fetch from an address that is not owned sets `qOe` to all zeros.
- R11: `nearFull` is 1 exactly when (write pointer − synchronised read pointer) mod span ≥ `fullThr`. It is computed in the `wrClk` domain.
- R12: `nearEmpty` is 1 exactly when (synchronised write pointer − read pointer) mod span ≤ `emptyThr`. It is computed in the `rdClk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| wrEnN | input | 1 | Active-low write enable (pipelined one cycle) |
| storeEnN | input | 1 | Active-low store permit; high inhibits storing only |
| wrClrN | input | 1 | Active-low write-pointer clear |
| wrSetN | input | 1 | Active-low write-pointer load |
| wrSelExt | input | 1 | Write load source: 1 external bus, 0 preset |
| wrPreset | input | PTR_W | Programmed write load address |
| dIn | input | 12 | Write data |
| rdEnN | input | 1 | Active-low read enable (pipelined one cycle) |
| rdClrN | input | 1 | Active-low read-pointer clear |
| rdSetN | input | 1 | Active-low read-pointer load |
| rdSelExt | input | 1 | Read load source: 1 external bus, 0 preset |
| rdPreset | input | PTR_W | Programmed read load address |
| extAddr | input | 24 | External jump address |
| widthMode | input | 2 | Data width selection |
| cascLog | input | CASC_W | log2 of instance count in the cascade |
| cascBase | input | CHIP_LOG_MAX | Position of this instance in the cascade |
| fullThr | input | PTR_W | Near-full threshold |
| emptyThr | input | PTR_W | Near-empty threshold |
| qOut | output | 12 | Read data |
| qOe | output | 12 | Per-bit output-drive enable |
| nearFull | output | 1 | Near-full flag (write domain) |
| nearEmpty | output | 1 | Near-empty flag (read domain) |

## Verification
Two pairs of functions can act in the same cycle, and both pairs are provoked on purpose. In the first pair, a held write clear lands on edges where pipelined enables would otherwise store. The bench holds `wrClrN` low for the first three store edges of a six-sample burst. It reads back from zero and expects only the last three samples. In the second pair, the empty stop meets continued read enables. The bench writes three samples and then reads five, expecting the third sample twice more. Every expected value comes from a bench-side memory image and pointer model. Sweeps over the flag levels and over every width mode compare the outputs with values computed by arithmetic.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  localparam int DATA_W = 12;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_10 = 2'd1,
    WID_12 = 2'd2,
    WID_ALT = 2'd3
  } widthSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic store;
    logic load;
    logic rdOwn;
  } fbp_strobe_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] mode);
    case (mode)
      WID_8:   laneMask = 12'hFF0;
      WID_12:  laneMask = 12'hFFF;
      default: laneMask = 12'hFFC;
    endcase
  endfunction
endpackage

// File: rtl/fbp_gray_sync.sv
`timescale 1ns/1ps
module fbp_gray_sync #(
  parameter int W = 7
) (
  input  logic         srcClk,
  input  logic         dstClk,
  input  logic         rstN,
  input  logic [W-1:0] binIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] srcGray, metaGray, dstGray;

  always_ff @(posedge srcClk or negedge rstN)
    if (!rstN) srcGray <= '0;
    else       srcGray <= binIn ^ (binIn >> 1);

  always_ff @(posedge dstClk or negedge rstN)
    if (!rstN) begin
      metaGray <= '0;
      dstGray  <= '0;
    end else begin
      metaGray <= srcGray;
      dstGray  <= metaGray;
    end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign binOut[i] = ^(dstGray >> i);
  end
endmodule

// File: rtl/fbp_ctrl.sv
`timescale 1ns/1ps
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CHIP_LOG_MAX = 3,
  parameter int EXT_W        = 24,
  localparam int PTR_W       = ADDR_W + CHIP_LOG_MAX,
  localparam int CASC_W      = $clog2(CHIP_LOG_MAX + 1)
) (
  input  logic                    wrClk,
  input  logic                    rdClk,
  input  logic                    rstN,
  input  logic                    wrEnN,
  input  logic                    storeEnN,
  input  logic                    wrClrN,
  input  logic                    wrSetN,
  input  logic                    wrSelExt,
  input  logic [PTR_W-1:0]        wrPreset,
  input  logic                    rdEnN,
  input  logic                    rdClrN,
  input  logic                    rdSetN,
  input  logic                    rdSelExt,
  input  logic [PTR_W-1:0]        rdPreset,
  input  logic [EXT_W-1:0]        extAddr,
  input  logic [CASC_W-1:0]       cascLog,
  input  logic [CHIP_LOG_MAX-1:0] cascBase,
  input  logic [PTR_W-1:0]        fullThr,
  input  logic [PTR_W-1:0]        emptyThr,
  output fbp_strobe_t             stb,
  output logic [ADDR_W-1:0]       wrLocal,
  output logic [ADDR_W-1:0]       rdLocal,
  output logic                    nearFull,
  output logic                    nearEmpty
);
  typedef logic [PTR_W-1:0] ptr_t;
  localparam ptr_t ALL_ONES = '1;

  ptr_t spanMask, wrPtr, rdPtr, wrTarget, rdTarget, rdAddr;
  ptr_t wrSyncR, rdSyncW;
  logic wrEnQ, rdEnQ, wrForce, rdForce, rdFree, rdEmpty, wrOwn;
  logic unusedExtHi;

  assign unusedExtHi = ^extAddr[EXT_W-1:PTR_W];
  assign spanMask = ALL_ONES >> (CHIP_LOG_MAX - int'(cascLog));

  // ---------------- write domain ----------------
  assign wrForce = !wrClrN || !wrSetN;
  always_comb begin
    if (!wrClrN)       wrTarget = '0;
    else if (wrSelExt) wrTarget = extAddr[PTR_W-1:0] & spanMask;
    else               wrTarget = wrPreset & spanMask;
  end

  assign wrOwn     = (wrPtr[PTR_W-1:ADDR_W] == cascBase);
  assign stb.store = wrEnQ && !wrForce && !storeEnN && wrOwn;
  assign wrLocal   = wrPtr[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge rstN)
    if (!rstN) begin
      wrEnQ <= 1'b0;
      wrPtr <= '0;
    end else begin
      wrEnQ <= !wrEnN;
      if (wrForce)    wrPtr <= wrTarget;
      else if (wrEnQ) wrPtr <= (wrPtr + PTR_W'(1)) & spanMask;
    end

  fbp_gray_sync #(.W(PTR_W)) u_rd2wr (
    .srcClk(rdClk), .dstClk(wrClk), .rstN(rstN), .binIn(rdPtr), .binOut(rdSyncW)
  );

  assign nearFull = (((wrPtr - rdSyncW) & spanMask) >= fullThr);

  // ---------------- read domain ----------------
  assign rdForce = !rdClrN || !rdSetN;
  always_comb begin
    if (!rdClrN)       rdTarget = '0;
    else if (rdSelExt) rdTarget = extAddr[PTR_W-1:0] & spanMask;
    else               rdTarget = rdPreset & spanMask;
  end

  fbp_gray_sync #(.W(PTR_W)) u_wr2rd (
    .srcClk(wrClk), .dstClk(rdClk), .rstN(rstN), .binIn(wrPtr), .binOut(wrSyncR)
  );

  assign rdEmpty   = !rdFree && (rdPtr == wrSyncR);
  assign rdAddr    = rdEmpty ? ((rdPtr - PTR_W'(1)) & spanMask) : rdPtr;
  assign stb.load  = rdEnQ && !rdForce;
  assign stb.rdOwn = (rdAddr[PTR_W-1:ADDR_W] == cascBase);
  assign rdLocal   = rdAddr[ADDR_W-1:0];

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN) begin
      rdEnQ  <= 1'b0;
      rdPtr  <= '0;
      rdFree <= 1'b0;
    end else begin
      rdEnQ  <= !rdEnN;
      rdFree <= rdFree || rdForce;
      if (rdForce)                 rdPtr <= rdTarget;
      else if (rdEnQ && !rdEmpty)  rdPtr <= (rdPtr + PTR_W'(1)) & spanMask;
    end

  assign nearEmpty = (((wrSyncR - rdPtr) & spanMask) <= emptyThr);

  // ---------------- assertions ----------------
  a_r1_store_needs_prev_enable: assert property (@(posedge wrClk) disable iff (!rstN)
    stb.store |-> $past(!wrEnN));

  a_r2_inhibit_still_advances: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEnQ && !wrForce && storeEnN) |=> (wrPtr == (($past(wrPtr) + PTR_W'(1)) & $past(spanMask))));

  a_r6_clear_holds_zero: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrClrN |=> (wrPtr == '0));

  a_r4_empty_read_holds: assert property (@(posedge rdClk) disable iff (!rstN)
    (stb.load && !rdFree && (rdPtr == wrSyncR)) |=> $stable(rdPtr));

  a_r5_read_clear_zero: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdClrN |=> (rdPtr == '0));
endmodule

// File: rtl/fbp_datapath.sv
`timescale 1ns/1ps
module fbp_datapath
  import fbp_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fbp_strobe_t       stb,
  input  logic [ADDR_W-1:0] wrLocal,
  input  logic [ADDR_W-1:0] rdLocal,
  input  logic [DATA_W-1:0] dIn,
  input  logic [1:0]        widthMode,
  output logic [DATA_W-1:0] qOut,
  output logic [DATA_W-1:0] qOe
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] qReg;
  logic              qOwn;

  always_ff @(posedge wrClk)
    if (stb.store) mem[wrLocal] <= dIn & laneMask(widthMode);

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN) begin
      qReg <= '0;
      qOwn <= 1'b0;
    end else if (stb.load) begin
      qReg <= mem[rdLocal];
      qOwn <= stb.rdOwn;
    end

  assign qOe  = qOwn ? laneMask(widthMode) : '0;
  assign qOut = qReg & qOe;

  a_r9_drive_shape: assert property (@(posedge rdClk) disable iff (!rstN)
    (qOe == '0) || (qOe == laneMask(widthMode)));

  a_r10_foreign_fetch_undriven: assert property (@(posedge rdClk) disable iff (!rstN)
    (stb.load && !stb.rdOwn) |=> (qOe == '0));
endmodule

// File: rtl/framebuf_ptr_ctrl.sv
`timescale 1ns/1ps
module framebuf_ptr_ctrl
  import fbp_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CHIP_LOG_MAX = 3,
  parameter int EXT_W        = 24,
  localparam int PTR_W       = ADDR_W + CHIP_LOG_MAX,
  localparam int CASC_W      = $clog2(CHIP_LOG_MAX + 1)
) (
  input  logic                    wrClk,
  input  logic                    rdClk,
  input  logic                    rstN,
  input  logic                    wrEnN,
  input  logic                    storeEnN,
  input  logic                    wrClrN,
  input  logic                    wrSetN,
  input  logic                    wrSelExt,
  input  logic [PTR_W-1:0]        wrPreset,
  input  logic [11:0]             dIn,
  input  logic                    rdEnN,
  input  logic                    rdClrN,
  input  logic                    rdSetN,
  input  logic                    rdSelExt,
  input  logic [PTR_W-1:0]        rdPreset,
  input  logic [EXT_W-1:0]        extAddr,
  input  logic [1:0]              widthMode,
  input  logic [CASC_W-1:0]       cascLog,
  input  logic [CHIP_LOG_MAX-1:0] cascBase,
  input  logic [PTR_W-1:0]        fullThr,
  input  logic [PTR_W-1:0]        emptyThr,
  output logic [11:0]             qOut,
  output logic [11:0]             qOe,
  output logic                    nearFull,
  output logic                    nearEmpty
);
  fbp_strobe_t       stb;
  logic [ADDR_W-1:0] wrLocal, rdLocal;

  fbp_ctrl #(.ADDR_W(ADDR_W), .CHIP_LOG_MAX(CHIP_LOG_MAX), .EXT_W(EXT_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .storeEnN(storeEnN), .wrClrN(wrClrN), .wrSetN(wrSetN),
    .wrSelExt(wrSelExt), .wrPreset(wrPreset),
    .rdEnN(rdEnN), .rdClrN(rdClrN), .rdSetN(rdSetN),
    .rdSelExt(rdSelExt), .rdPreset(rdPreset),
    .extAddr(extAddr), .cascLog(cascLog), .cascBase(cascBase),
    .fullThr(fullThr), .emptyThr(emptyThr),
    .stb(stb), .wrLocal(wrLocal), .rdLocal(rdLocal),
    .nearFull(nearFull), .nearEmpty(nearEmpty)
  );

  fbp_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrLocal(wrLocal), .rdLocal(rdLocal), .dIn(dIn), .widthMode(widthMode),
    .qOut(qOut), .qOe(qOe)
  );
endmodule

// File: tb/framebuf_ptr_ctrl_test.sv
`timescale 1ns/1ps
module framebuf_ptr_ctrl_test;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 16;
  localparam int PTR_W  = 7;
  localparam int GSPAN  = 128;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEnN = 1, storeEnN = 0, wrClrN = 1, wrSetN = 1, wrSelExt = 0;
  logic rdEnN = 1, rdClrN = 1, rdSetN = 1, rdSelExt = 0;
  logic [PTR_W-1:0] wrPreset = '0, rdPreset = '0, fullThr = 7'd12, emptyThr = 7'd3;
  logic [11:0] dIn = '0;
  logic [23:0] extAddr = '0;
  logic [1:0]  widthMode = 2'd1;
  logic [1:0]  cascLog = 2'd0;
  logic [2:0]  cascBase = 3'd0;
  logic [11:0] qOut, qOe;
  logic nearFull, nearEmpty;

  logic [11:0] model [GSPAN];
  int wp = 0, rp = 0, nRun = 0, nFail = 0;
  bit rdFreeB = 0;

  framebuf_ptr_ctrl uut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .storeEnN(storeEnN), .wrClrN(wrClrN), .wrSetN(wrSetN),
    .wrSelExt(wrSelExt), .wrPreset(wrPreset), .dIn(dIn),
    .rdEnN(rdEnN), .rdClrN(rdClrN), .rdSetN(rdSetN),
    .rdSelExt(rdSelExt), .rdPreset(rdPreset), .extAddr(extAddr),
    .widthMode(widthMode), .cascLog(cascLog), .cascBase(cascBase),
    .fullThr(fullThr), .emptyThr(emptyThr),
    .qOut(qOut), .qOe(qOe), .nearFull(nearFull), .nearEmpty(nearEmpty)
  );

  always #10 wrClk = ~wrClk;
  initial begin #7; forever #10 rdClk = ~rdClk; end

  function automatic logic [11:0] mask12(input logic [1:0] m);
    return (m == 2'd0) ? 12'hFF0 : (m == 2'd2) ? 12'hFFF : 12'hFFC;
  endfunction
  function automatic int spanB();
    return DEPTH << cascLog;
  endfunction
  function automatic bit own(input int a);
    return (a >> ADDR_W) == int'(cascBase);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge wrClk);
  endtask

  // write burst; item i inhibited when (i % inhEvery == inhEvery-1); clear held for first clrFirst stores
  task automatic writeBurst(input int count, input int base, input int inhEvery, input int clrFirst);
    @(negedge wrClk); wrEnN = 0;
    @(negedge wrClk);
    for (int i = 0; i < count; i++) begin
      if (i == count - 1) wrEnN = 1;
      dIn = 12'((base + i * 13) & 'hFFF);
      storeEnN = (inhEvery > 0) && (i % inhEvery == inhEvery - 1);
      wrClrN = !(i < clrFirst);
      @(negedge wrClk);
      if (i < clrFirst) wp = 0;
      else begin
        if (!storeEnN && own(wp)) model[wp] = dIn & mask12(widthMode);
        wp = (wp + 1) % spanB();
      end
    end
    storeEnN = 0; wrClrN = 1;
  endtask

  task automatic readBurst(input int count, input string req);
    int addr;
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk);
    for (int i = 0; i < count; i++) begin
      if (i == count - 1) rdEnN = 1;
      @(negedge rdClk);
      if (!rdFreeB && rp == wp) addr = (rp - 1 + spanB()) % spanB();
      else begin addr = rp; rp = (rp + 1) % spanB(); end
      if (own(addr)) begin
        check(req, 32'(qOut), 32'(model[addr] & mask12(widthMode)));
        check(req, 32'(qOe), 32'(mask12(widthMode)));
      end else check(req, 32'(qOe), 32'h0);
    end
  endtask

  task automatic forceWr(input bit clr, input bit useExt, input int val);
    if (useExt) extAddr = 24'(val); else wrPreset = PTR_W'(val);
    wrSelExt = useExt;
    @(negedge wrClk); wrClrN = !clr; wrSetN = clr;
    @(negedge wrClk); wrClrN = 1; wrSetN = 1;
    wp = clr ? 0 : ((val % GSPAN) & (spanB() - 1));
  endtask

  task automatic forceRd(input bit clr, input bit useExt, input int val);
    if (useExt) extAddr = 24'(val); else rdPreset = PTR_W'(val);
    rdSelExt = useExt;
    @(negedge rdClk); rdClrN = !clr; rdSetN = clr;
    @(negedge rdClk); rdClrN = 1; rdSetN = 1;
    rp = clr ? 0 : ((val % GSPAN) & (spanB() - 1));
    rdFreeB = 1;
  endtask

  task automatic checkFlags(input int level, input string req);
    check({req, " nearFull R11"}, 32'(nearFull), 32'(level >= int'(fullThr)));
    check({req, " nearEmpty R12"}, 32'(nearEmpty), 32'(level <= int'(emptyThr)));
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [11:0] prev;
    repeat (3) @(negedge wrClk);
    rstN = 1;
    @(negedge wrClk);
    // reset state
    check("R8 reset qOe", 32'(qOe), 0);
    check("R8 reset qOut", 32'(qOut), 0);
    checkFlags(0, "reset");

    // R1 + R4: pipelined write, then empty hold re-reads last sample
    writeBurst(3, 'h3A0, 0, 0);
    idle(6);
    readBurst(5, "R1 R4 empty hold");

    // R3: overwrite past full
    forceWr(1, 0, 0); forceRd(1, 0, 0);
    writeBurst(DEPTH + 3, 'h140, 0, 0);
    forceRd(1, 0, 0);
    readBurst(DEPTH, "R3 overwrite");

    // R2: inhibit every second store, pointer keeps advancing
    forceWr(1, 0, 0);
    writeBurst(DEPTH, 'h800, 2, 0);
    forceRd(1, 0, 0);
    readBurst(DEPTH, "R2 inhibit");
    writeBurst(1, 'h5F0, 0, 0);
    forceRd(1, 0, 0);
    readBurst(1, "R2 pointer wrapped");

    // R6: held clear overlapping a write burst
    forceWr(1, 0, 0);
    writeBurst(6, 'h2C0, 0, 3);
    forceRd(1, 0, 0);
    readBurst(3, "R6 held clear");

    // R5: load from preset (ext bus holds a different value)
    extAddr = '0;
    forceWr(0, 0, 9);
    writeBurst(2, 'h610, 0, 0);
    forceRd(0, 0, 9);
    readBurst(2, "R5 preset load");

    // R7: load from external bus, upper bits ignored
    forceWr(0, 1, 'hABC003);
    writeBurst(2, 'h720, 0, 0);
    forceRd(0, 1, 'h5A0003);
    readBurst(2, "R7 external load");

    // R8: two-edge latency and skip
    forceRd(1, 0, 0);
    prev = qOut;
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); check("R8 no data after one edge", 32'(qOut), 32'(prev)); rdEnN = 1;
    @(negedge rdClk); check("R8 data after two edges", 32'(qOut), 32'(model[0] & 12'hFFC));
    @(negedge rdClk); check("R8 skip holds", 32'(qOut), 32'(model[0] & 12'hFFC)); rdEnN = 0;
    @(negedge rdClk); check("R8 skip holds 2", 32'(qOut), 32'(model[0] & 12'hFFC)); rdEnN = 1;
    @(negedge rdClk); check("R8 next sample", 32'(qOut), 32'(model[1] & 12'hFFC));
    rp = 2;

    // R9: every width mode
    for (int m = 0; m < 4; m++) begin
      widthMode = 2'(m);
      forceWr(1, 0, 0);
      writeBurst(2, 'hA5F, 0, 0);
      forceRd(1, 0, 0);
      readBurst(2, "R9 width");
    end
    widthMode = 2'd1;

    // R10: cascade of two, this instance second
    cascLog = 2'd1; cascBase = 3'd1;
    forceWr(1, 0, 0); forceRd(1, 0, 0);
    writeBurst(2, 'h330, 0, 0);
    forceRd(1, 0, 0);
    readBurst(1, "R10 foreign slice");
    forceWr(0, 1, 16);
    writeBurst(2, 'h350, 0, 0);
    forceRd(0, 1, 16);
    readBurst(2, "R10 own slice");
    forceWr(0, 1, 31);
    writeBurst(2, 'h370, 0, 0);
    forceRd(0, 1, 31);
    readBurst(2, "R10 R3 span wrap");
    cascLog = 2'd0; cascBase = 3'd0;

    // R11 / R12: level sweep up then down
    forceWr(1, 0, 0); forceRd(1, 0, 0);
    for (int n = 0; n < DEPTH; n++) begin
      idle(6);
      checkFlags(n, "fill");
      if (n < DEPTH - 1) writeBurst(1, 'h900 + n * 3, 0, 0);
    end
    for (int n = DEPTH - 2; n >= 0; n--) begin
      readBurst(1, "R12 drain data");
      idle(6);
      checkFlags(n, "drain");
    end

    finishRun();
  end
endmodule